// File: doc/BRIEF.md
# BCD Real-Time Clock with Alarm

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours, day of month, month, two-digit year and a weekday number. A one-cycle pulse on `sec_tick` advances the time by one second while the run bit is set. Software reaches everything through a synchronous byte-wide register port. The time fields and the alarm fields sit in contiguous windows, so a driver can read or write either group as a burst. A control register starts and stops counting, chooses 12- or 24-hour hours and requests a coherent snapshot. A status register holds sticky event flags that are cleared by writing a one. An interrupt-enable register routes either a periodic event or the alarm match to the single level `irq` output.

Reads of the time window always return a shadow copy. Setting the snapshot bit in the control register copies all seven live counters into the shadow in the same clock, so a burst read never mixes values from either side of a carry. The time counters accept writes only while the clock is stopped. A two-state update sequencer manages each second. In `SQ_WAIT` it idles. An enabled tick takes it to `SQ_CHECK` (transition *advance*) as the counters step. In `SQ_CHECK` it derives the periodic events from the new time and compares the time with the alarm. It then returns to `SQ_WAIT` (transition *settle*), or stays in `SQ_CHECK` if another enabled tick is already present (transition *re-advance*).

Top module: `rtc_bcd_top`

## Requirements
- R1: After reset the status register (offset 0x0E) reads 0x80: only the power-up flag, bit 7, is set. The control register (0x0D) reads 0x00, the time shadow reads 00:00:00 on day 01, month 01, year 00, weekday 0, `irq` is low, and any unmapped offset reads 0x00. Read data appears on `rdata` one clock after `rd_en`.
- R2: With the clock running, each tick advances seconds (offset 0x00) and minutes (0x01) from 59 to 00 with a carry. In 24-hour mode hours (0x02) step from 23 to 00 with a carry into the day. Each tick sets status bit 2. A minute carry sets bit 3, an hour carry sets bit 4 and a day carry sets bit 5.
- R3: The day (0x03) wraps to 01 after the last day of its month. April, June, September and November have 30 days, February has 28, or 29 when the year is divisible by 4, and the other months have 31. Month (0x04) wraps from 12 to 01 and steps the year (0x05), which wraps from 99 to 00. The weekday (0x06) steps on each day carry and wraps from 6 to 0.
- R4: When control bit 3 is 1 (12-hour mode), hours hold 01 to 12 in BCD, with bit 7 as the PM flag. 11:59:59 rolls to 12:00:00 with PM toggled, 12:59:59 rolls to 01:00:00, and only the step from 11 PM to 12 AM carries into the day.
- R5: Ticks advance the time only while control bit 0 is 1. Status bit 1 reads as control bit 0.
- R6: Writes to offsets 0x00 to 0x06 load the live counters while control bit 0 is 0 and are ignored while it is 1.
- R7: Writing control bit 6 as 1 copies all seven live counters into the shadow that offsets 0x00 to 0x06 read. The shadow keeps that copy until the next request, and control bit 6 always reads 0.
- R8: On the cycle after each counted tick, the alarm flag (status bit 6) is set if seconds, minutes, hours (including the PM bit), day, month and year all equal the alarm registers.
- R9: Writing 1 to any of status bits 2 to 7 clears that flag. A 0 leaves it unchanged, and a flag set in the same cycle as a clear stays set.
- R10: `irq` is high while the alarm flag is set and interrupt-enable bit 3 is 1. It is also high while interrupt-enable bit 2 is 1 and the event flag chosen by bits [1:0] is set (0 second, 1 minute, 2 hour, 3 day). It stays high until software clears that flag.
- R11: Alarm registers at offsets 0x07 to 0x0C (alarm seconds to alarm year) and the interrupt-enable register at 0x0F read back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered on `rd_en` |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the carries: end of a 28-day February, a leap-year February, end of year 99, and the weekday wrap. A design with a wrong month-length table or leap test would land on an invalid date or skip one. In 12-hour mode it crosses 11 AM, 12 PM and 11 PM, where a misplaced PM toggle or day carry would give the wrong half-day or lose a day. It checks that the shadow holds after later ticks, that time writes are dropped while running, and that a stopped clock stays frozen; a design that read the live counters or ignored the run bit would fail there. On the alarm side it tests the tick before the match and the match itself, that the alarm stays pending until cleared, and a periodic select where a second tick must not assert `irq` but a minute carry must.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;
    localparam int FIELD_CNT = 7;
    localparam int ALM_CNT   = 6;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HR   = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YR   = 5;
    localparam int F_WDAY = 6;

    localparam int A_ALM0 = 7;
    localparam int A_ALML = A_ALM0 + ALM_CNT - 1;
    localparam int A_CTRL = 13;
    localparam int A_STAT = 14;
    localparam int A_IEN  = 15;

    typedef logic [7:0] bcd_t;
    typedef bcd_t [FIELD_CNT-1:0] tvec_t;

    localparam tvec_t TIME_RST = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    typedef enum logic {SQ_WAIT, SQ_CHECK} seq_t;

    function automatic bcd_t bcd_inc(input bcd_t v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    function automatic bcd_t month_len(input bcd_t mon, input bcd_t yr);
        logic [7:0] ybin;
        ybin = ({4'b0, yr[7:4]} * 8'd10) + {4'b0, yr[3:0]};
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       h12,
    input  logic       ld_en,
    input  logic [2:0] ld_idx,
    input  bcd_t       ld_val,
    output tvec_t      now
);
    tvec_t nxt;
    logic  c_min, c_hr, c_day, c_mon;
    bcd_t  hv;

    always_comb begin
        nxt   = now;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        hv    = now[F_HR] & 8'h7F;
        if (now[F_SEC] == 8'h59) begin
            nxt[F_SEC] = 8'h00;
            c_min      = 1'b1;
        end else nxt[F_SEC] = bcd_inc(now[F_SEC]);
        if (c_min) begin
            if (now[F_MIN] == 8'h59) begin
                nxt[F_MIN] = 8'h00;
                c_hr       = 1'b1;
            end else nxt[F_MIN] = bcd_inc(now[F_MIN]);
        end
        if (c_hr) begin
            if (h12) begin
                if (hv == 8'h11) begin
                    nxt[F_HR] = {~now[F_HR][7], 7'h12};
                    c_day     = now[F_HR][7];
                end else if (hv == 8'h12) nxt[F_HR] = {now[F_HR][7], 7'h01};
                else nxt[F_HR] = {now[F_HR][7], 7'(bcd_inc(hv))};
            end else if (now[F_HR] == 8'h23) begin
                nxt[F_HR] = 8'h00;
                c_day     = 1'b1;
            end else nxt[F_HR] = bcd_inc(now[F_HR]);
        end
        if (c_day) begin
            nxt[F_WDAY] = (now[F_WDAY] == 8'h06) ? 8'h00 : bcd_inc(now[F_WDAY]);
            if (now[F_DAY] == month_len(now[F_MON], now[F_YR])) begin
                nxt[F_DAY] = 8'h01;
                c_mon      = 1'b1;
            end else nxt[F_DAY] = bcd_inc(now[F_DAY]);
        end
        if (c_mon) begin
            if (now[F_MON] == 8'h12) begin
                nxt[F_MON] = 8'h01;
                nxt[F_YR]  = (now[F_YR] == 8'h99) ? 8'h00 : bcd_inc(now[F_YR]);
            end else nxt[F_MON] = bcd_inc(now[F_MON]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     now <= TIME_RST;
        else if (adv)   now <= nxt;
        else if (ld_en) now[ld_idx] <= ld_val;
    end
endmodule

// File: rtl/rtc_bcd_alarm_match.sv
module rtc_bcd_alarm_match
    import rtc_bcd_pkg::*;
#(
    parameter int N = ALM_CNT
) (
    input  bcd_t [N-1:0] cur,
    input  bcd_t [N-1:0] alm,
    output logic         hit
);
    logic [N-1:0] eq;
    for (genvar g = 0; g < N; g++) begin : g_field
        assign eq[g] = (cur[g] == alm[g]);
    end
    assign hit = &eq;
endmodule

// File: rtl/rtc_bcd_top.sv
module rtc_bcd_top
    import rtc_bcd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);

    tvec_t              live_t, shadow_q;
    bcd_t [ALM_CNT-1:0] alm_q;
    logic               run_q, h12_q, alarm_q, pwr_q;
    logic [3:0]         ien_q, ev_q, ev_hit;
    logic               alm_hit, alarm_set, adv, in_time, in_alm;
    logic [2:0]         alm_idx;
    logic [7:0]         st_clr, rd_mux;
    seq_t               seq_q, seq_d;

    assign adv     = sec_tick & run_q;
    assign in_time = addr < ADDR_W'(FIELD_CNT);
    assign in_alm  = (addr >= ADDR_W'(A_ALM0)) && (addr <= ADDR_W'(A_ALML));
    assign alm_idx = 3'(addr - ADDR_W'(A_ALM0));
    assign st_clr  = (wr_en && addr == AD_STAT) ? wdata : 8'h00;

    rtc_bcd_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(adv), .h12(h12_q),
        .ld_en(wr_en & in_time & ~run_q), .ld_idx(addr[2:0]),
        .ld_val(wdata), .now(live_t)
    );

    rtc_bcd_alarm_match #(.N(ALM_CNT)) u_match (
        .cur(live_t[ALM_CNT-1:0]), .alm(alm_q), .hit(alm_hit)
    );

    // update sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SQ_WAIT;
        else        seq_q <= seq_d;
    end

    // update sequencer: next state and outputs
    always_comb begin
        seq_d     = seq_q;
        ev_hit    = 4'b0000;
        alarm_set = 1'b0;
        unique case (seq_q)
            SQ_WAIT: begin
                if (adv) seq_d = SQ_CHECK;
            end
            SQ_CHECK: begin
                ev_hit[0] = 1'b1;
                ev_hit[1] = (live_t[F_SEC] == 8'h00);
                ev_hit[2] = ev_hit[1] && (live_t[F_MIN] == 8'h00);
                ev_hit[3] = ev_hit[2] && (live_t[F_HR] == (h12_q ? 8'h12 : 8'h00));
                alarm_set = alm_hit;
                seq_d     = adv ? SQ_CHECK : SQ_WAIT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q    <= 4'b0000;
            alarm_q <= 1'b0;
            pwr_q   <= 1'b1;
        end else begin
            ev_q    <= (ev_q & ~st_clr[5:2]) | ev_hit;
            alarm_q <= (alarm_q & ~st_clr[6]) | alarm_set;
            pwr_q   <= pwr_q & ~st_clr[7];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            h12_q    <= 1'b0;
            ien_q    <= 4'b0000;
            alm_q    <= '0;
            shadow_q <= TIME_RST;
        end else if (wr_en) begin
            if (addr == AD_CTRL) begin
                run_q <= wdata[0];
                h12_q <= wdata[3];
                if (wdata[6]) shadow_q <= live_t;
            end
            if (addr == AD_IEN) ien_q <= wdata[3:0];
            if (in_alm) alm_q[alm_idx] <= wdata;
        end
    end

    always_comb begin
        rd_mux = 8'h00;
        if (in_time)              rd_mux = shadow_q[addr[2:0]];
        else if (in_alm)          rd_mux = alm_q[alm_idx];
        else if (addr == AD_CTRL) rd_mux = {4'b0000, h12_q, 2'b00, run_q};
        else if (addr == AD_STAT) rd_mux = {pwr_q, alarm_q, ev_q, run_q, 1'b0};
        else if (addr == AD_IEN)  rd_mux = {4'b0000, ien_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= 8'h00;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq = (ien_q[3] & alarm_q) | (ien_q[2] & ev_q[ien_q[1:0]]);
endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk
    import rtc_bcd_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sec_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              run,
    input logic              alarm_flag,
    input logic              alarm_en,
    input logic              timer_en,
    input logic              in_check,
    input logic              irq,
    input tvec_t             live,
    input tvec_t             shadow
);
    // R5
    frozen_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && addr < ADDR_W'(FIELD_CNT))) |=> $stable(live));

    // R6
    run_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !sec_tick && wr_en && addr < ADDR_W'(FIELD_CNT)) |=> $stable(live));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && run && live[F_SEC] == 8'h59) |=> (live[F_SEC] == 8'h00));

    // R7
    snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_CTRL) && wdata[6]) |=> (shadow == $past(live)));

    // R9
    alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(wr_en && addr == ADDR_W'(A_STAT) && wdata[6])) |=> alarm_flag);

    // R8
    alarm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(in_check));

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (alarm_en || timer_en));
endmodule

bind rtc_bcd_top rtc_bcd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .run(run_q), .alarm_flag(alarm_q),
    .alarm_en(ien_q[3]), .timer_en(ien_q[2]),
    .in_check(seq_q == rtc_bcd_pkg::SQ_CHECK), .irq(irq),
    .live(live_t), .shadow(shadow_q)
);

// File: tb/rtc_bcd_top_test.sv
module rtc_bcd_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] ctrl_v = 8'h00;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    rtc_bcd_top uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compares read data against the scoreboard queue
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) check("scoreboard-underflow", 8'h00, 8'h01);
                else check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    // drivers: all called at a negedge, return at a negedge
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ctrl(input logic [7:0] v);
        ctrl_v = v;
        wr(5'h0D, v);
    endtask

    task automatic snap();
        wr(5'h0D, ctrl_v | 8'h40);
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 0;
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                        input logic [7:0] w);
        wr(5'h00, s); wr(5'h01, m); wr(5'h02, h); wr(5'h03, d);
        wr(5'h04, mo); wr(5'h05, y); wr(5'h06, w);
    endtask

    task automatic irq_is(input logic exp, input string tag);
        check(tag, {7'b0, irq}, {7'b0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 8'h00, 8'h01);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'h0E, 8'h80, "R1 status");
        rd(5'h0D, 8'h00, "R1 ctrl");
        rd(5'h15, 8'h00, "R1 unmapped");
        rd(5'h00, 8'h00, "R1 sec");
        rd(5'h03, 8'h01, "R1 day");
        irq_is(1'b0, "R1 irq");

        // R9 power-up flag clear
        wr(5'h0E, 8'h80);
        rd(5'h0E, 8'h00, "R9 pwr clear");

        // R2 R3 end of February 2023, full carry chain
        load(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h06);
        ctrl(8'h01);
        tick();
        snap();
        rd(5'h00, 8'h59, "R2 sec step");
        rd(5'h0E, 8'h06, "R2 sec flag");
        rd(5'h0D, 8'h01, "R7 snap bit reads 0");
        wr(5'h0E, 8'h3C);
        tick();
        snap();
        rd(5'h00, 8'h00, "R2 sec wrap");
        rd(5'h01, 8'h00, "R2 min wrap");
        rd(5'h02, 8'h00, "R2 hour wrap");
        rd(5'h03, 8'h01, "R3 day wrap feb");
        rd(5'h04, 8'h03, "R3 month step");
        rd(5'h05, 8'h23, "R3 year kept");
        rd(5'h06, 8'h00, "R3 weekday wrap");
        rd(5'h0E, 8'h3E, "R2 all flags");

        // R5 stopped: run bit low, flags kept
        ctrl(8'h00);
        rd(5'h0E, 8'h3C, "R5 run bit low");
        wr(5'h0E, 8'h3C);

        // R3 leap year February
        load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h02);
        ctrl(8'h01);
        tick();
        snap();
        rd(5'h03, 8'h29, "R3 leap day 29");
        rd(5'h04, 8'h02, "R3 leap month kept");
        ctrl(8'h00);
        load(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h03);
        ctrl(8'h01);
        tick();
        snap();
        rd(5'h03, 8'h01, "R3 leap end day");
        rd(5'h04, 8'h03, "R3 leap end month");

        // R3 end of year 99
        ctrl(8'h00);
        load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h03);
        ctrl(8'h01);
        tick();
        snap();
        rd(5'h03, 8'h01, "R3 year end day");
        rd(5'h04, 8'h01, "R3 year end month");
        rd(5'h05, 8'h00, "R3 year wrap");
        rd(5'h06, 8'h04, "R3 weekday step");

        // R5 tick while stopped has no effect
        ctrl(8'h00);
        tick();
        snap();
        rd(5'h00, 8'h00, "R5 frozen sec");

        // R6 write while running ignored
        ctrl(8'h01);
        wr(5'h00, 8'h30);
        snap();
        rd(5'h00, 8'h00, "R6 write dropped");

        // R7 shadow holds across a tick
        tick();
        rd(5'h00, 8'h00, "R7 shadow held");
        snap();
        rd(5'h00, 8'h01, "R7 new snapshot");

        // R4 12-hour mode
        ctrl(8'h08);
        load(8'h59, 8'h59, 8'h11, 8'h05, 8'h05, 8'h10, 8'h01);
        ctrl(8'h09);
        tick();
        snap();
        rd(5'h02, 8'h92, "R4 11AM to 12PM");
        rd(5'h03, 8'h05, "R4 noon no day");
        ctrl(8'h08);
        wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h02, 8'h92);
        ctrl(8'h09);
        tick();
        snap();
        rd(5'h02, 8'h81, "R4 12PM to 1PM");
        ctrl(8'h08);
        wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h02, 8'h91);
        wr(5'h0E, 8'hFC);
        ctrl(8'h09);
        tick();
        snap();
        rd(5'h02, 8'h12, "R4 11PM to 12AM");
        rd(5'h03, 8'h06, "R4 midnight day");
        rd(5'h0E, 8'h3E, "R4 day flag");

        // R8 R10 R11 alarm
        ctrl(8'h00);
        load(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h30, 8'h02);
        wr(5'h07, 8'h32); wr(5'h08, 8'h20); wr(5'h09, 8'h10);
        wr(5'h0A, 8'h15); wr(5'h0B, 8'h06); wr(5'h0C, 8'h30);
        rd(5'h08, 8'h20, "R11 alarm min");
        rd(5'h0C, 8'h30, "R11 alarm year");
        wr(5'h0F, 8'h08);
        rd(5'h0F, 8'h08, "R11 ien readback");
        wr(5'h0E, 8'hFC);
        ctrl(8'h01);
        tick();
        irq_is(1'b0, "R8 no early alarm");
        rd(5'h0E, 8'h06, "R8 no alarm flag");
        tick();
        irq_is(1'b1, "R8 alarm irq");
        rd(5'h0E, 8'h46, "R8 alarm flag");
        tick();
        irq_is(1'b1, "R10 alarm irq held");
        wr(5'h0E, 8'h40);
        irq_is(1'b0, "R9 alarm cleared");
        rd(5'h0E, 8'h06, "R9 other flags kept");

        // R10 periodic interrupt on minute events
        wr(5'h0F, 8'h05);
        wr(5'h0E, 8'hFC);
        tick();
        irq_is(1'b0, "R10 sec event not selected");
        ctrl(8'h00);
        wr(5'h00, 8'h59);
        ctrl(8'h01);
        tick();
        irq_is(1'b1, "R10 minute irq");
        wr(5'h0E, 8'h08);
        irq_is(1'b0, "R10 minute cleared");

        repeat (3) @(negedge clk);
        check("R1 scoreboard drained", 8'(exp_q.size()), 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule